// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the register side of a small accumulator machine. One 16-bit bus joins six working registers and a 4096-word memory. A 3-bit source code picks which of them drives the bus. Each destination register has its own load, increment and clear strobes, and all of them act on the rising clock edge. The memory address always comes from the address register, so a write always lands at the word that register points to.

The address register and the program counter are 12 bits wide, while the bus is 16 bits wide. When either of them drives the bus, the top bits are filled with zeros. When either of them loads from the bus, it keeps only the low bits. The accumulator takes its load value from an arithmetic unit outside the block, so that result arrives on a port. The 8-bit output register takes the low byte of the bus. The sequencer that drives the strobes is outside the block.

Top module: `shared_bus_datapath`

## Requirements
- R1: `bus_sel` picks the bus source: 0 drives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register and 7 the memory word at the address register.
- R2: When a load strobe is high, the data, temporary and instruction registers take the bus value on the next rising edge. The accumulator instead takes `alu_value`.
- R3: When an increment strobe is high, the register gains one on the next edge. The result wraps modulo its width: 0xFFF goes to 0x000 and 0xFFFF goes to 0x0000.
- R4: A clear strobe forces the register to zero. If several strobes are high on one register in the same cycle, clear wins over load and load wins over increment.
- R5: The instruction register changes only through its load strobe. In every other cycle it holds its value.
- R6: When the address register or the program counter drives the bus, bus bits 15..12 are zero.
- R7: When the address register or the program counter loads from the bus, it stores bus bits 11..0.
- R8: When `mem_wr` is high, the bus value is stored at the memory word addressed by the address register as it was before that edge. Source code 7 then reads the word back.
- R9: When `outr_ld` is high, the 8-bit output register takes bus bits 7..0.
- R10: A synchronous active-high `rst` sets every register to zero. The memory contents are not reset.
- R11: A register that drives the bus can load, increment or clear on the same edge. The bus and any other destination see its value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 3 | Bus source code |
| alu_value | input | 16 | Arithmetic result loaded into the accumulator |
| ar_ld | input | 1 | Address register load from bus |
| ar_inr | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load from bus |
| pc_inr | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load from bus |
| dr_inr | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| ac_ld | input | 1 | Accumulator load from `alu_value` |
| ac_inr | input | 1 | Accumulator increment |
| ac_clr | input | 1 | Accumulator clear |
| tr_ld | input | 1 | Temporary register load from bus |
| tr_inr | input | 1 | Temporary register increment |
| tr_clr | input | 1 | Temporary register clear |
| ir_ld | input | 1 | Instruction register load from bus |
| outr_ld | input | 1 | Output register load from bus bits 7..0 |
| mem_wr | input | 1 | Write bus into memory at the address register |
| bus_out | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| outr_q | output | 8 | Output register |

## Verification
Two functions can fall in the same cycle: a memory write and a load of the address register, and a source register driving the bus while it also modifies itself. The bench provokes the first by writing the accumulator to memory while the same bus value reloads the address register. It then steps the address register back and reads source 7, which shows the data landed at the old address. For the second, the bench selects the address register as the source, loads the program counter from it and increments the address register in the same cycle. It then expects the program counter to hold the value from before the increment, and the address register to hold that value plus one.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

endpackage

// File: rtl/bus_register.sv
module bus_register #(
  parameter int W       = 16,
  parameter bit HAS_INR = 1'b1,
  parameter bit HAS_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         inr,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  // clear over load over increment
  function automatic logic [W-1:0] step_value(
    input logic [W-1:0] cur, input logic [W-1:0] din,
    input logic do_ld, input logic do_inr, input logic do_clr);
    if (do_clr)      return '0;
    else if (do_ld)  return din;
    else if (do_inr) return cur + ONE;
    else             return cur;
  endfunction

  logic inr_en, clr_en;
  assign inr_en = inr && HAS_INR;
  assign clr_en = clr && HAS_CLR;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= step_value(q, d, ld, inr_en, clr_en);
  end
endmodule

// File: rtl/bus_source_mux.sv
module bus_source_mux
  import cbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] ar,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] dr,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] ir,
  input  logic [DATA_W-1:0] tr,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] bus
);
  function automatic logic [DATA_W-1:0] widen(input logic [ADDR_W-1:0] a);
    return DATA_W'(a);
  endfunction

  always_comb begin
    unique case (bus_src_e'(sel))
      SRC_AR:  bus = widen(ar);
      SRC_PC:  bus = widen(pc);
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/word_memory.sv
module word_memory #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wr) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_sel,
  input  logic [DATA_W-1:0] alu_value,
  input  logic              ar_ld,
  input  logic              ar_inr,
  input  logic              ar_clr,
  input  logic              pc_ld,
  input  logic              pc_inr,
  input  logic              pc_clr,
  input  logic              dr_ld,
  input  logic              dr_inr,
  input  logic              dr_clr,
  input  logic              ac_ld,
  input  logic              ac_inr,
  input  logic              ac_clr,
  input  logic              tr_ld,
  input  logic              tr_inr,
  input  logic              tr_clr,
  input  logic              ir_ld,
  input  logic              outr_ld,
  input  logic              mem_wr,
  output logic [DATA_W-1:0] bus_out,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] tr_q,
  output logic [OUT_W-1:0]  outr_q
);
  logic [DATA_W-1:0] bus_w;
  logic [DATA_W-1:0] mem_rdata;
  logic [ADDR_W-1:0] bus_addr_part;
  logic [OUT_W-1:0]  bus_byte_part;

  assign bus_addr_part = bus_w[ADDR_W-1:0];
  assign bus_byte_part = bus_w[OUT_W-1:0];
  assign bus_out       = bus_w;

  bus_source_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mux (
    .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
    .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus_w));

  word_memory #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .clk(clk), .wr(mem_wr), .addr(ar_q), .wdata(bus_w), .rdata(mem_rdata));

  bus_register #(.W(ADDR_W)) i_ar (
    .clk(clk), .rst(rst), .ld(ar_ld), .inr(ar_inr), .clr(ar_clr),
    .d(bus_addr_part), .q(ar_q));

  bus_register #(.W(ADDR_W)) i_pc (
    .clk(clk), .rst(rst), .ld(pc_ld), .inr(pc_inr), .clr(pc_clr),
    .d(bus_addr_part), .q(pc_q));

  bus_register #(.W(DATA_W)) i_dr (
    .clk(clk), .rst(rst), .ld(dr_ld), .inr(dr_inr), .clr(dr_clr),
    .d(bus_w), .q(dr_q));

  bus_register #(.W(DATA_W)) i_ac (
    .clk(clk), .rst(rst), .ld(ac_ld), .inr(ac_inr), .clr(ac_clr),
    .d(alu_value), .q(ac_q));

  bus_register #(.W(DATA_W)) i_tr (
    .clk(clk), .rst(rst), .ld(tr_ld), .inr(tr_inr), .clr(tr_clr),
    .d(bus_w), .q(tr_q));

  bus_register #(.W(DATA_W), .HAS_INR(1'b0), .HAS_CLR(1'b0)) i_ir (
    .clk(clk), .rst(rst), .ld(ir_ld), .inr(1'b0), .clr(1'b0),
    .d(bus_w), .q(ir_q));

  bus_register #(.W(OUT_W), .HAS_INR(1'b0), .HAS_CLR(1'b0)) i_outr (
    .clk(clk), .rst(rst), .ld(outr_ld), .inr(1'b0), .clr(1'b0),
    .d(bus_byte_part), .q(outr_q));
endmodule

// File: rtl/bus_datapath_checker.sv
module bus_datapath_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_sel,
  input logic              ar_ld,
  input logic              ar_inr,
  input logic              ar_clr,
  input logic              pc_ld,
  input logic              pc_clr,
  input logic              dr_ld,
  input logic              dr_clr,
  input logic              tr_clr,
  input logic              ir_ld,
  input logic              outr_ld,
  input logic [DATA_W-1:0] bus_out,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] dr_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] tr_q,
  input logic [OUT_W-1:0]  outr_q
);
  assert_zero_source_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == 3'd0) |-> (bus_out == '0));

  assert_dr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (dr_ld && !dr_clr) |=> (dr_q == $past(bus_out)));

  assert_ar_wrap_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (ar_inr && !ar_ld && !ar_clr) |=> (ar_q == $past(ar_q) + ADDR_W'(1)));

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
    tr_clr |=> (tr_q == '0));

  assert_ir_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ir_ld |=> $stable(ir_q));

  assert_addr_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> (bus_out[DATA_W-1:ADDR_W] == '0));

  assert_pc_low_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && !pc_clr) |=> (pc_q == $past(bus_out[ADDR_W-1:0])));

  assert_outr_byte_R9: assert property (@(posedge clk) disable iff (rst)
    outr_ld |=> (outr_q == $past(bus_out[OUT_W-1:0])));
endmodule

bind shared_bus_datapath bus_datapath_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)
) i_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel),
  .ar_ld(ar_ld), .ar_inr(ar_inr), .ar_clr(ar_clr),
  .pc_ld(pc_ld), .pc_clr(pc_clr), .dr_ld(dr_ld), .dr_clr(dr_clr),
  .tr_clr(tr_clr), .ir_ld(ir_ld), .outr_ld(outr_ld),
  .bus_out(bus_out), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q),
  .ir_q(ir_q), .tr_q(tr_q), .outr_q(outr_q));

// File: tb/test_shared_bus_datapath.sv
`timescale 1ns/1ps
module test_shared_bus_datapath;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [2:0]  bus_sel;
  logic [15:0] alu_value;
  logic ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr;
  logic dr_ld, dr_inr, dr_clr, ac_ld, ac_inr, ac_clr;
  logic tr_ld, tr_inr, tr_clr, ir_ld, outr_ld, mem_wr;
  logic [15:0] bus_out, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  logic [7:0]  outr_q;

  shared_bus_datapath i_shared_bus_datapath (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // ld bits {outr,ir,tr,ac,dr,pc,ar}; inr/clr bits {tr,ac,dr,pc,ar}
  // obs: bus source code shown after the step; 0 means look at outr_q
  typedef struct packed {
    logic [2:0]  sel;
    logic [6:0]  ld;
    logic [4:0]  inr;
    logic [4:0]  clr;
    logic        wr;
    logic [15:0] alu;
    logic [2:0]  obs;
    logic [15:0] exp;
    logic [7:0]  req;
  } row_t;

  localparam int NROWS = 29;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0, 7'h08, 5'h00, 5'h00, 1'b0, 16'hBEEF, 3'd4, 16'hBEEF, 8'd2},  // R2 AC from alu
    '{3'd4, 7'h04, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd3, 16'hBEEF, 8'd2},  // R2 DR from bus
    '{3'd4, 7'h11, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd1, 16'h0EEF, 8'd7},  // R7 AR low bits
    '{3'd0, 7'h00, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd6, 16'hBEEF, 8'd2},  // R2 TR took bus
    '{3'd3, 7'h02, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd2, 16'h0EEF, 8'd7},  // R7 PC low bits
    '{3'd4, 7'h20, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd5, 16'hBEEF, 8'd5},  // R5 IR load
    '{3'd4, 7'h00, 5'h00, 5'h00, 1'b1, 16'h0000, 3'd7, 16'hBEEF, 8'd8},  // R8 write M[EEF]
    '{3'd0, 7'h00, 5'h01, 5'h00, 1'b0, 16'h0000, 3'd1, 16'h0EF0, 8'd3},  // R3 AR+1
    '{3'd4, 7'h00, 5'h00, 5'h00, 1'b1, 16'h0000, 3'd7, 16'hBEEF, 8'd8},  // R8 write M[EF0]
    '{3'd0, 7'h00, 5'h00, 5'h00, 1'b1, 16'h0000, 3'd7, 16'h0000, 8'd1},  // R1 zero source
    '{3'd6, 7'h40, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd0, 16'h00EF, 8'd9},  // R9 OUTR byte
    '{3'd4, 7'h10, 5'h10, 5'h10, 1'b0, 16'h0000, 3'd6, 16'h0000, 8'd4},  // R4 clr wins
    '{3'd2, 7'h04, 5'h04, 5'h00, 1'b0, 16'h0000, 3'd3, 16'h0EEF, 8'd4},  // R4 ld over inr
    '{3'd3, 7'h20, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd5, 16'h0EEF, 8'd5},  // R5 IR load
    '{3'd4, 7'h1F, 5'h00, 5'h00, 1'b0, 16'h5555, 3'd5, 16'h0EEF, 8'd5},  // R5 IR holds
    '{3'd0, 7'h08, 5'h00, 5'h00, 1'b0, 16'hFFFF, 3'd4, 16'hFFFF, 8'd2},  // R2
    '{3'd0, 7'h00, 5'h08, 5'h00, 1'b0, 16'h0000, 3'd4, 16'h0000, 8'd3},  // R3 16-bit wrap
    '{3'd0, 7'h08, 5'h00, 5'h00, 1'b0, 16'h1234, 3'd4, 16'h1234, 8'd2},  // R2
    '{3'd4, 7'h01, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd1, 16'h0234, 8'd7},  // R7
    '{3'd1, 7'h02, 5'h01, 5'h00, 1'b0, 16'h0000, 3'd2, 16'h0234, 8'd11}, // R11 PC sees old AR
    '{3'd0, 7'h00, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd1, 16'h0235, 8'd11}, // R11 AR moved on
    '{3'd4, 7'h01, 5'h00, 5'h00, 1'b1, 16'h0000, 3'd1, 16'h0234, 8'd11}, // R11 write + AR load
    '{3'd0, 7'h00, 5'h01, 5'h00, 1'b0, 16'h0000, 3'd7, 16'h1234, 8'd8},  // R8 landed at old AR
    '{3'd0, 7'h08, 5'h00, 5'h00, 1'b0, 16'hFFFF, 3'd4, 16'hFFFF, 8'd2},  // R2
    '{3'd4, 7'h01, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd1, 16'h0FFF, 8'd6},  // R6 upper zero
    '{3'd0, 7'h00, 5'h01, 5'h00, 1'b0, 16'h0000, 3'd1, 16'h0000, 8'd3},  // R3 12-bit wrap
    '{3'd0, 7'h00, 5'h02, 5'h02, 1'b0, 16'h0000, 3'd2, 16'h0000, 8'd4},  // R4 clr over inr
    '{3'd5, 7'h10, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd6, 16'h0EEF, 8'd1},  // R1 IR source
    '{3'd0, 7'h04, 5'h00, 5'h00, 1'b0, 16'h0000, 3'd3, 16'h0000, 8'd1}   // R1 zero into DR
  };

  task automatic idle_ctrl();
    {ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr} = '0;
    {dr_ld, dr_inr, dr_clr, ac_ld, ac_inr, ac_clr} = '0;
    {tr_ld, tr_inr, tr_clr, ir_ld, outr_ld, mem_wr} = '0;
  endtask

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all_zero(input int req);
    check(req, {4'h0, ar_q}, 16'h0);
    check(req, {4'h0, pc_q}, 16'h0);
    check(req, dr_q, 16'h0);
    check(req, ac_q, 16'h0);
    check(req, ir_q, 16'h0);
    check(req, tr_q, 16'h0);
    check(req, {8'h0, outr_q}, 16'h0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    bus_sel = 3'd0;
    alu_value = '0;
    idle_ctrl();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check_all_zero(10);  // R10 reset state
    check(1, bus_out, 16'h0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      bus_sel = ROWS[i].sel;
      alu_value = ROWS[i].alu;
      {outr_ld, ir_ld, tr_ld, ac_ld, dr_ld, pc_ld, ar_ld} = ROWS[i].ld;
      {tr_inr, ac_inr, dr_inr, pc_inr, ar_inr} = ROWS[i].inr;
      {tr_clr, ac_clr, dr_clr, pc_clr, ar_clr} = ROWS[i].clr;
      mem_wr = ROWS[i].wr;
      @(negedge clk);
      idle_ctrl();
      bus_sel = ROWS[i].obs;
      #1;
      if (ROWS[i].obs == 3'd0) check(ROWS[i].req, {8'h0, outr_q}, ROWS[i].exp);
      else                     check(ROWS[i].req, bus_out, ROWS[i].exp);
    end

    // R6: program counter at all ones on the bus keeps top nibble zero
    @(negedge clk);
    alu_value = 16'hFFFF; ac_ld = 1'b1;
    @(negedge clk);
    idle_ctrl(); bus_sel = 3'd4; pc_ld = 1'b1;
    @(negedge clk);
    idle_ctrl(); bus_sel = 3'd2;
    #1;
    check(6, bus_out, 16'h0FFF);

    // R10: reset from a non-zero state, memory kept
    @(negedge clk);
    outr_ld = 1'b1; dr_ld = 1'b1; tr_ld = 1'b1; ar_inr = 1'b1; bus_sel = 3'd4;
    @(negedge clk);
    idle_ctrl();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; bus_sel = 3'd0;
    #1;
    check_all_zero(10);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule